// File: doc/BRIEF.md
# Per-Channel Digital Volume Attenuator

This block scales each audio sample by a gain chosen separately for each of eight channels, on its way to the reconstruction filters. A sample enters with a 3-bit channel index and a valid flag. The block reads that channel's 8-bit attenuation code, turns the code into a gain and multiplies. The rounded and clamped result leaves two clock cycles later, together with its channel index.

One code step is 0.375 dB, so sixteen steps make 6 dB. The gain is therefore a 16-entry mantissa, picked by the low four bits of the code, shifted right by the high four bits. This replaces a full 256-entry gain table. The largest code silences the channel completely.

Settings are written through a simple byte-wide write port. Channel c sits at address 0x06 + c.

Top module: `vol_atten`

## Requirements
- R1: After reset, out_valid and out_sample are 0 and every channel's code is 0, which is unity gain.
- R2: A sample presented with in_valid high comes out with out_valid high exactly two rising edges later, with the same channel index on out_ch. out_valid is never high without such an input, and samples may arrive back to back on every cycle.
- R3: For a code k below 255, the gain is g = M[k mod 16] >> (k div 16), with M[i] = round(32768 · 10^(−0.375·i/20)). The output is floor((x·g + 16384) / 32768), which rounds half up, clamped to the 24-bit two's-complement range.
- R4: Code 0 passes every 24-bit sample through unchanged.
- R5: Code 255 makes the output 0 for every sample.
- R6: Each of the eight channels applies only its own code. Writing one channel's code leaves the output of the others unchanged.
- R7: A write with cfg_we high to address 0x06 + c, for c from 0 to 7, sets channel c's code to cfg_wdata. A write to any other address changes no code.
- R8: A code is picked up when a sample enters. A sample presented in the same cycle as a write to its channel uses the previous code, and the next sample uses the new one.
- R9: The output never exceeds the input in magnitude. It has the sign of the input, or it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for a setting |
| cfg_addr | input | 8 | Setting address; channel c is at 0x06 + c |
| cfg_wdata | input | 8 | Attenuation code, in 0.375 dB steps |
| in_valid | input | 1 | Input sample present |
| in_ch | input | 3 | Channel index of the input sample |
| in_sample | input | 24 | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_ch | output | 3 | Channel index of the output sample |
| out_sample | output | 24 | Signed, attenuated output sample |

## Verification
The assertions assume that in_valid, in_ch and in_sample hold known values on every edge once reset has been released. They also assume that each gain handed to the multiply stage never exceeds unity, which the mantissa table guarantees for all 255 codes. The bench drives every input from time zero and changes it only on falling clock edges. It sweeps all 256 codes on every channel and gives each channel a different code in the same pass. It uses full-scale, unit-size and mixed samples, and these reach the rounding and clamping edges.

// File: rtl/vol_pkg.sv
package vol_pkg;

    localparam int GAIN_W    = 16;
    localparam int GAIN_FRAC = 15;
    localparam int MANT_IDXW = 4;

    // round(32768 * 10^(-0.375*i/20)) for i = 0..15
    function automatic logic [GAIN_W-1:0] mant_lookup(input logic [MANT_IDXW-1:0] idx);
        logic [GAIN_W-1:0] m;
        case (idx)
            4'd0:    m = 16'd32768;
            4'd1:    m = 16'd31383;
            4'd2:    m = 16'd30057;
            4'd3:    m = 16'd28787;
            4'd4:    m = 16'd27571;
            4'd5:    m = 16'd26406;
            4'd6:    m = 16'd25290;
            4'd7:    m = 16'd24221;
            4'd8:    m = 16'd23198;
            4'd9:    m = 16'd22218;
            4'd10:   m = 16'd21279;
            4'd11:   m = 16'd20380;
            4'd12:   m = 16'd19519;
            4'd13:   m = 16'd18694;
            4'd14:   m = 16'd17904;
            default: m = 16'd17147;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vol_bank.sv
module vol_bank #(
    parameter int              NCH  = 8,
    parameter int              KW   = 8,
    parameter int              AW   = 8,
    parameter logic [AW-1:0]   BASE = 8'h06,
    localparam int             CHW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AW-1:0]  addr,
    input  logic [KW-1:0]  wdata,
    input  logic [CHW-1:0] rd_ch,
    output logic [KW-1:0]  rd_k
);

    logic [NCH-1:0][KW-1:0] bank_d, bank_q;
    logic [AW-1:0]          offset;
    logic [NCH-1:0]         sel;

    assign offset = addr - BASE;

    for (genvar c = 0; c < NCH; c++) begin : g_sel
        assign sel[c] = we && (offset == AW'(c));
    end

    always_comb begin
        bank_d = bank_q;
        for (int c = 0; c < NCH; c++) begin
            if (sel[c]) begin
                bank_d[c] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_k = bank_q[rd_ch];

    // R7: an address outside the channel window leaves every code alone
    assert_foreign_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || (addr < BASE) || (addr >= BASE + AW'(NCH))) |=> $stable(bank_q));

    // R7: a write inside the window lands in the addressed channel
    assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr >= BASE) && (addr < BASE + AW'(NCH)))
        |=> (bank_q[$past(offset[CHW-1:0])] == $past(wdata)));

endmodule

// File: rtl/vol_gain.sv
module vol_gain #(
    parameter int KW = 8,
    parameter int GW = vol_pkg::GAIN_W,
    localparam int IW  = vol_pkg::MANT_IDXW,
    localparam int SHW = KW - IW
) (
    input  logic [KW-1:0] k,
    output logic [GW-1:0] g
);

    logic [IW-1:0]  idx;
    logic [SHW-1:0] sh;
    logic [GW-1:0]  mant;

    always_comb begin
        idx  = k[IW-1:0];
        sh   = k[KW-1:IW];
        mant = GW'(vol_pkg::mant_lookup(idx));
        if (k == '1) begin
            g = '0;
        end else begin
            g = mant >> sh;
        end
    end

endmodule

// File: rtl/vol_mult.sv
module vol_mult #(
    parameter int SW   = 24,
    parameter int GW   = vol_pkg::GAIN_W,
    parameter int FRAC = vol_pkg::GAIN_FRAC,
    parameter int CHW  = 3,
    localparam int PW  = SW + GW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic [CHW-1:0]       ch_i,
    input  logic signed [SW-1:0] x_i,
    input  logic [GW-1:0]        g_i,
    output logic                 v_o,
    output logic [CHW-1:0]       ch_o,
    output logic signed [SW-1:0] y_o
);

    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);
    localparam logic signed [PW-1:0] MAXV = PW'((64'd1 << (SW - 1)) - 64'd1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);
    localparam logic [GW-1:0]        UNITY = GW'(1) << FRAC;

    typedef struct packed {
        logic                 v;
        logic [CHW-1:0]       ch;
        logic signed [SW-1:0] y;
    } out_t;

    out_t out_d, out_q;
    logic signed [PW-1:0] xe, ge, prod, scaled;

    always_comb begin
        xe     = PW'(x_i);
        ge     = $signed(PW'(g_i));
        prod   = xe * ge;
        scaled = (prod + HALF) >>> FRAC;
        out_d    = out_q;
        out_d.v  = v_i;
        if (v_i) begin
            out_d.ch = ch_i;
            if (scaled > MAXV) begin
                out_d.y = MAXV[SW-1:0];
            end else if (scaled < MINV) begin
                out_d.y = MINV[SW-1:0];
            end else begin
                out_d.y = scaled[SW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign v_o  = out_q.v;
    assign ch_o = out_q.ch;
    assign y_o  = out_q.y;

    // R2: valid and channel follow the stage input by one edge
    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        v_i |=> (v_o && ch_o == $past(ch_i)));
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !v_i |=> !v_o);

    // R5: a zero gain gives a zero sample
    assert_mute_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (v_i && g_i == '0) |=> (y_o == '0));

    // R4: a unity gain passes the sample unchanged
    assert_unity_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (v_i && g_i == UNITY) |=> (y_o == $past(x_i)));

    // R9: the magnitude never grows and the sign never flips
    assert_magnitude_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (v_i && g_i <= UNITY) |=>
        (($past(x_i) >= 0) ? (y_o >= 0 && y_o <= $past(x_i))
                           : (y_o <= 0 && y_o >= $past(x_i))));

endmodule

// File: rtl/vol_atten.sv
module vol_atten #(
    parameter int            NCH  = 8,
    parameter int            SW   = 24,
    parameter int            KW   = 8,
    parameter int            AW   = 8,
    parameter logic [AW-1:0] BASE = 8'h06,
    localparam int           CHW  = $clog2(NCH),
    localparam int           GW   = vol_pkg::GAIN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [AW-1:0]        cfg_addr,
    input  logic [KW-1:0]        cfg_wdata,
    input  logic                 in_valid,
    input  logic [CHW-1:0]       in_ch,
    input  logic signed [SW-1:0] in_sample,
    output logic                 out_valid,
    output logic [CHW-1:0]       out_ch,
    output logic signed [SW-1:0] out_sample
);

    typedef struct packed {
        logic                 v;
        logic [CHW-1:0]       ch;
        logic signed [SW-1:0] x;
        logic [GW-1:0]        g;
    } front_t;

    front_t front_d, front_q;
    logic [KW-1:0] cur_k;
    logic [GW-1:0] cur_g;

    vol_bank #(.NCH(NCH), .KW(KW), .AW(AW), .BASE(BASE)) bank_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rd_ch (in_ch),
        .rd_k  (cur_k)
    );

    vol_gain #(.KW(KW), .GW(GW)) gain_i (
        .k (cur_k),
        .g (cur_g)
    );

    // The code is latched with the sample, so a write in the same cycle
    // only affects later samples.
    always_comb begin
        front_d   = front_q;
        front_d.v = in_valid;
        if (in_valid) begin
            front_d.ch = in_ch;
            front_d.x  = in_sample;
            front_d.g  = cur_g;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            front_q <= '0;
        end else begin
            front_q <= front_d;
        end
    end

    vol_mult #(.SW(SW), .GW(GW), .FRAC(vol_pkg::GAIN_FRAC), .CHW(CHW)) mult_i (
        .clk   (clk),
        .rst_n (rst_n),
        .v_i   (front_q.v),
        .ch_i  (front_q.ch),
        .x_i   (front_q.x),
        .g_i   (front_q.g),
        .v_o   (out_valid),
        .ch_o  (out_ch),
        .y_o   (out_sample)
    );

    // R2: first stage captures valid, channel and sample on the entry edge
    assert_entry_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (front_q.v && front_q.ch == $past(in_ch) && front_q.x == $past(in_sample)));

    // R8: a write to the entering channel does not reach the latched gain
    assert_old_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_we && cfg_addr == BASE + AW'(in_ch)) |=> (front_q.g == $past(cur_g)));

endmodule

// File: tb/vol_atten_tb_top.sv
module vol_atten_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_ch = '0;
    logic [23:0] in_sample = '0;
    logic        out_valid;
    logic [2:0]  out_ch;
    logic [23:0] out_sample;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int model_k [8];

    logic [23:0] q_exp [$];
    int          q_ch  [$];
    int          q_at  [$];
    string       q_tag [$];

    vol_atten dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ch(in_ch),
        .in_sample(in_sample), .out_valid(out_valid), .out_ch(out_ch),
        .out_sample(out_sample)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [23:0] expect_out(input int xin, input int k);
        int     m;
        int     g;
        longint p;
        longint r;
        if (k == 255) return 24'd0;
        m = $rtoi(32768.0 * (10.0 ** (-0.375 * real'(k % 16) / 20.0)) + 0.5);
        g = m >> (k / 16);
        p = longint'(xin) * longint'(g);
        r = (p + 64'sd16384) >>> 15;
        if (r > 64'sd8388607) r = 64'sd8388607;
        if (r < -64'sd8388608) r = -64'sd8388608;
        return r[23:0];
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One cycle of stimulus, driven on the falling edge
    task automatic step(input bit v, input int ch, input int x,
                        input bit we, input int addr, input int data, input string tag);
        @(negedge clk);
        in_valid  = v;
        in_ch     = 3'(ch);
        in_sample = 24'(x);
        cfg_we    = we;
        cfg_addr  = 8'(addr);
        cfg_wdata = 8'(data);
        if (v) begin
            q_exp.push_back(expect_out(x, model_k[ch]));
            q_ch.push_back(ch);
            q_at.push_back(cyc + 2);
            q_tag.push_back(tag);
        end
        if (we && addr >= 6 && addr < 14) model_k[addr - 6] = data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0, 0, 0, "");
    endtask

    // Output monitor: R2 timing and channel, value per the stored tag
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (rst_n) begin
                if (out_valid) begin
                    if (q_exp.size() == 0) begin
                        check(1'b0, "R2", "unexpected out_valid", 1, 0);
                    end else begin
                        check(q_at[0] == cyc, "R2", "output cycle", cyc, q_at[0]);
                        check(int'(out_ch) == q_ch[0], "R2", "out_ch", out_ch, q_ch[0]);
                        check(out_sample == q_exp[0], q_tag[0], "out_sample",
                              $signed(out_sample), $signed(q_exp[0]));
                        void'(q_exp.pop_front()); void'(q_ch.pop_front());
                        void'(q_at.pop_front());  void'(q_tag.pop_front());
                    end
                end else if (q_exp.size() != 0 && q_at[0] <= cyc) begin
                    check(1'b0, "R2", "missing out_valid", 0, 1);
                    void'(q_exp.pop_front()); void'(q_ch.pop_front());
                    void'(q_at.pop_front());  void'(q_tag.pop_front());
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        check(1'b0, "R2", "watchdog expired", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic int pick_sample(input int sel, input int it, input int c);
        case (sel % 5)
            0:       return 8388607;
            1:       return -8388608;
            2:       return ((sel / 5) % 2 == 0) ? -1 : 1;
            3:       return ((it * 7919 + c * 104729) % 8388608) - 4194304;
            default: return -((it + 1) * 12345 + c * 777);
        endcase
    endfunction

    initial begin
        for (int c = 0; c < 8; c++) model_k[c] = 0;
        repeat (3) @(posedge clk);
        #3;
        // R1: outputs idle during reset
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        check(out_sample == 24'd0, "R1", "out_sample in reset", out_sample, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

        // R1: default code is unity on every channel
        for (int c = 0; c < 8; c++) step(1'b1, c, 1234567 - c * 99991, 1'b0, 0, 0, "R1");
        idle(4);

        // R3 R4 R5 R6: every code on every channel, each channel a different code
        for (int it = 0; it < 256; it++) begin
            for (int c = 0; c < 8; c++) step(1'b0, 0, 0, 1'b1, 6 + c, (it + 37 * c) % 256, "");
            for (int j = 0; j < 3; j++) begin
                for (int c = 0; c < 8; c++) begin
                    int    k;
                    int    x;
                    string t;
                    k = (it + 37 * c) % 256;
                    x = pick_sample(it + c + j, it, c);
                    if (k == 0)                        t = "R4";
                    else if (k == 255)                 t = "R5";
                    else if (x == 8388607 || x == -8388608) t = "R9";
                    else if (j == 2)                   t = "R6";
                    else                               t = "R3";
                    step(1'b1, c, x, 1'b0, 0, 0, t);
                end
            end
        end
        idle(4);

        // R7: known codes, then writes outside the window
        for (int c = 0; c < 8; c++) step(1'b0, 0, 0, 1'b1, 6 + c, 16 * c + 3, "");
        step(1'b0, 0, 0, 1'b1, 5, 255, "");
        step(1'b0, 0, 0, 1'b1, 14, 255, "");
        step(1'b0, 0, 0, 1'b1, 255, 255, "");
        step(1'b0, 0, 0, 1'b1, 0, 255, "");
        for (int c = 0; c < 8; c++) step(1'b1, c, 5000000, 1'b0, 0, 0, "R7");
        idle(4);

        // R8: write and sample of the same channel in one cycle
        step(1'b0, 0, 0, 1'b1, 9, 0, "");
        step(1'b1, 3, -7654321, 1'b1, 9, 255, "R8");
        step(1'b1, 3, -7654321, 1'b0, 0, 0, "R8");
        step(1'b1, 3, 222222, 1'b1, 9, 16, "R8");
        step(1'b1, 3, 222222, 1'b0, 0, 0, "R8");
        idle(6);

        // R2: nothing left outstanding after idle cycles
        check(q_exp.size() == 0, "R2", "outstanding outputs", q_exp.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule